// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block runs simultaneous-sample conversion scans over up to eight analog channels and keeps the results in a small FIFO for a bus-side reader. A scan is launched by a read strobe on the start register or by a falling edge on a hardware source. The hardware source is chosen between an external trigger pin and a timer output. At launch the block snapshots the channel enable mask, pulses a sample-and-hold strobe once for all channels, and empties the FIFO. It then requests one conversion per enabled channel from an abstract converter port, in ascending channel order. Each returned 14-bit two's-complement result is stored as a 16-bit word with its two top bits cleared.

An active-low end-of-last-conversion flag is high while a scan runs. It drops once the last enabled channel has been stored and stays low until the next accepted launch. The reader pops one word per narrow read. A wide read pops two words at once, which models a 32-bit access across two mirrored 16-bit data addresses. A read that finds the FIFO empty repeats the last value returned and leaves the FIFO pointers unchanged.

Top module: `adc_scan_seq`

## Requirements
- R1: Only channels whose bit is 1 in `chanMask` at launch are requested; `convChan` holds a channel until `convValid` accepts it.
- R2: A cycle with `startRd` high while idle launches a scan; `convReq` goes high in the following cycle.
- R3: With `hwSrcSel` = 0 a falling edge on `extTrig` launches a scan and edges on `timerOut` have no effect; with `hwSrcSel` = 1 the roles swap.
- R4: `sampleHold` is high for exactly one cycle per non-empty scan, the cycle after launch, together with the first request.
- R5: `eolcN` is 1 from the cycle after launch until the last result is stored, then 0 until the next launch.
- R6: Every launch empties the FIFO, so that results left from an earlier scan are lost.
- R7: Results are read lowest channel first; a narrow read gives the word in `rdData[15:0]` with `rdData[31:14]` = 0.
- R8: A wide read pops two words, the older one in `rdData[15:0]` and the newer in `rdData[31:16]`; read data appears the cycle after the read strobe.
- R9: A launch request (read strobe or hardware edge) while a scan is busy is ignored.
- R10: A read of an empty FIFO returns the last value read, in both halves for a wide read, and does not move the pointers.
- R11: A launch with an all-zero mask makes no request and no hold pulse, keeps `eolcN` at 0 and leaves the FIFO empty.
- R12: After reset `eolcN`, `convReq`, `sampleHold` and `rdData` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanMask | input | 8 | Channel enable mask, bit n enables channel n |
| hwSrcSel | input | 1 | Hardware launch source: 0 external trigger, 1 timer |
| startRd | input | 1 | Read strobe of the start register |
| extTrig | input | 1 | External trigger, launches on falling edge |
| timerOut | input | 1 | Timer output, launches on falling edge |
| convReq | output | 1 | Conversion request for `convChan` |
| convChan | output | 3 | Channel being converted |
| sampleHold | output | 1 | One-cycle common sample strobe |
| convValid | input | 1 | Converter result valid |
| convData | input | 14 | Converter result, two's complement |
| rdEn | input | 1 | Data register read strobe |
| rdWide | input | 1 | Read is 32 bits wide and pops two words |
| rdData | output | 32 | Read data, valid the cycle after `rdEn` |
| eolcN | output | 1 | End of last conversion, active low |

## Verification
A converter model with variable latency answers requests while a behavioural queue model predicts every output each cycle. The channel masks used are sparse, full, two-bit and empty, which separates ordering errors from mask errors and from the zero-mask shortcut. Both hardware sources are toggled with each setting of the select bit, so a swapped or ignored select shows up. Launches during a busy scan, refills without drain, and reads past the last entry with both read widths separate flushing, busy masking and empty-read handling.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef struct packed {
    logic flush;
    logic push;
  } fifoCtl_t;
endpackage

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chanMask,
  input  logic              hwSrcSel,
  input  logic              startRd,
  input  logic              extTrig,
  input  logic              timerOut,
  input  logic              convValid,
  output logic              convReq,
  output logic [CH_W-1:0]   convChan,
  output logic              sampleHold,
  output logic              eolcN,
  output fifoCtl_t          fifoCtl
);
  typedef enum logic {IDLE, SCAN} state_t;

  localparam int NSRC = 2;

  state_t            state;
  logic [NUM_CH-1:0] scanLeft;
  logic [NUM_CH-1:0] leftAfter;
  logic [CH_W-1:0]   curChan;
  logic [NSRC-1:0]   srcIn;
  logic [NSRC-1:0]   srcFall;
  logic              startHit;

  // index 0: external trigger, index 1: timer output
  assign srcIn = {timerOut, extTrig};

  for (genvar g = 0; g < NSRC; g++) begin : g_edge
    logic prevLvl;
    always_ff @(posedge clk) begin
      if (!rstN) prevLvl <= 1'b0;
      else       prevLvl <= srcIn[g];
    end
    assign srcFall[g] = prevLvl & ~srcIn[g];
  end

  assign startHit = startRd | srcFall[hwSrcSel];

  always_comb begin
    curChan = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (scanLeft[i]) curChan = CH_W'(i);
    end
  end

  assign leftAfter = scanLeft & ~(NUM_CH'(1) << curChan);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= IDLE;
      scanLeft   <= '0;
      eolcN      <= 1'b0;
      sampleHold <= 1'b0;
    end else begin
      sampleHold <= 1'b0;
      case (state)
        IDLE: begin
          if (startHit) begin
            if (chanMask == '0) begin
              eolcN <= 1'b0;
            end else begin
              state      <= SCAN;
              scanLeft   <= chanMask;
              eolcN      <= 1'b1;
              sampleHold <= 1'b1;
            end
          end
        end
        SCAN: begin
          if (convValid) begin
            scanLeft <= leftAfter;
            if (leftAfter == '0) begin
              state <= IDLE;
              eolcN <= 1'b0;
            end
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  assign convReq       = (state == SCAN);
  assign convChan      = curChan;
  assign fifoCtl.flush = (state == IDLE) && startHit;
  assign fifoCtl.push  = (state == SCAN) && convValid;
endmodule

// File: rtl/adc_scan_path.sv
module adc_scan_path
  import adc_scan_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 14,
  parameter int WORD_W = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int RD_W   = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCtl_t          fifoCtl,
  input  logic [DATA_W-1:0] convData,
  input  logic              rdEn,
  input  logic              rdWide,
  output logic [RD_W-1:0]   rdData
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] rdPtr;
  logic [ADDR_W-1:0] wrPtr;
  logic [CNT_W-1:0]  count;
  logic [WORD_W-1:0] lastVal;
  logic [WORD_W-1:0] pushWord;
  logic [WORD_W-1:0] head0;
  logic [WORD_W-1:0] head1;
  logic [WORD_W-1:0] loWord;
  logic [WORD_W-1:0] hiWord;
  logic              avail1;
  logic              avail2;
  logic [1:0]        popN;
  logic              canPush;

  function automatic logic [ADDR_W-1:0] ptrAdd(input logic [ADDR_W-1:0] p, input int n);
    int s;
    s = int'(p) + n;
    if (s >= DEPTH) s = s - DEPTH;
    return ADDR_W'(s);
  endfunction

  assign pushWord = {{(WORD_W - DATA_W){1'b0}}, convData};
  assign head0    = mem[rdPtr];
  assign head1    = mem[ptrAdd(rdPtr, 1)];
  assign avail1   = (count >= CNT_W'(1));
  assign avail2   = (count >= CNT_W'(2));
  assign loWord   = avail1 ? head0 : lastVal;
  assign hiWord   = avail2 ? head1 : loWord;

  always_comb begin
    popN = 2'd0;
    if (rdEn) begin
      if (rdWide && avail2) popN = 2'd2;
      else if (avail1)      popN = 2'd1;
    end
  end

  assign canPush = fifoCtl.push && ((count != CNT_W'(DEPTH)) || (popN != 2'd0));

  always_ff @(posedge clk) begin
    if (canPush && !fifoCtl.flush) mem[wrPtr] <= pushWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (fifoCtl.flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      rdPtr <= ptrAdd(rdPtr, int'(popN));
      if (canPush) wrPtr <= ptrAdd(wrPtr, 1);
      count <= count + CNT_W'(canPush) - CNT_W'(popN);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      lastVal <= '0;
    end else if (rdEn) begin
      if (rdWide) begin
        rdData  <= {hiWord, loWord};
        lastVal <= hiWord;
      end else begin
        rdData  <= {{WORD_W{1'b0}}, loWord};
        lastVal <= loWord;
      end
    end
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 14,
  parameter int WORD_W = 16,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int RD_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chanMask,
  input  logic              hwSrcSel,
  input  logic              startRd,
  input  logic              extTrig,
  input  logic              timerOut,
  output logic              convReq,
  output logic [CH_W-1:0]   convChan,
  output logic              sampleHold,
  input  logic              convValid,
  input  logic [DATA_W-1:0] convData,
  input  logic              rdEn,
  input  logic              rdWide,
  output logic [RD_W-1:0]   rdData,
  output logic              eolcN
);
  fifoCtl_t fifoCtl;

  adc_scan_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .chanMask  (chanMask),
    .hwSrcSel  (hwSrcSel),
    .startRd   (startRd),
    .extTrig   (extTrig),
    .timerOut  (timerOut),
    .convValid (convValid),
    .convReq   (convReq),
    .convChan  (convChan),
    .sampleHold(sampleHold),
    .eolcN     (eolcN),
    .fifoCtl   (fifoCtl)
  );

  adc_scan_path #(.DEPTH(NUM_CH), .DATA_W(DATA_W), .WORD_W(WORD_W)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .fifoCtl (fifoCtl),
    .convData(convData),
    .rdEn    (rdEn),
    .rdWide  (rdWide),
    .rdData  (rdData)
  );
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic            convReq,
  input logic            convValid,
  input logic [CH_W-1:0] convChan,
  input logic            sampleHold,
  input logic            eolcN
);
  assert_hold_with_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    sampleHold |-> convReq);

  assert_hold_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    sampleHold |=> !sampleHold);

  assert_req_in_scan_R5: assert property (@(posedge clk) disable iff (!rstN)
    convReq |-> eolcN);

  assert_rise_with_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eolcN) |-> sampleHold);

  assert_chan_held_R1: assert property (@(posedge clk) disable iff (!rstN)
    (convReq && !convValid) |=> (convReq && $stable(convChan)));

  assert_chan_ascend_R7: assert property (@(posedge clk) disable iff (!rstN)
    (convReq && convValid) |=> (!convReq || (convChan > $past(convChan))));
endmodule

bind adc_scan_seq adc_scan_chk #(.CH_W(CH_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .convReq   (convReq),
  .convValid (convValid),
  .convChan  (convChan),
  .sampleHold(sampleHold),
  .eolcN     (eolcN)
);

// File: tb/tb_adc_scan_seq.sv
`timescale 1ns/1ps
module tb_adc_scan_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  chanMask = 8'h00;
  logic        hwSrcSel = 1'b0;
  logic        startRd = 1'b0;
  logic        extTrig = 1'b1;
  logic        timerOut = 1'b1;
  logic        convReq;
  logic [2:0]  convChan;
  logic        sampleHold;
  logic        convValid = 1'b0;
  logic [13:0] convData = '0;
  logic        rdEn = 1'b0;
  logic        rdWide = 1'b0;
  logic [31:0] rdData;
  logic        eolcN;

  int checks = 0;
  int errors = 0;
  int seed = 0;
  int lat = 1;
  int holdSeen = 0;
  bit done = 0;

  // converter model state
  bit   cBusy = 0;
  int   cCnt = 0;
  int   cChan = 0;

  // reference model state
  logic [15:0] q[$];
  bit          mBusy = 0;
  logic [7:0]  mLeft = 0;
  bit          mEolcN = 0;
  bit          mHold = 0;
  logic [15:0] mLast = 0;
  logic [31:0] mRd = 0;
  bit          mPrevE = 0;
  bit          mPrevT = 0;

  adc_scan_seq dut (
    .clk(clk), .rstN(rstN), .chanMask(chanMask), .hwSrcSel(hwSrcSel),
    .startRd(startRd), .extTrig(extTrig), .timerOut(timerOut),
    .convReq(convReq), .convChan(convChan), .sampleHold(sampleHold),
    .convValid(convValid), .convData(convData), .rdEn(rdEn), .rdWide(rdWide),
    .rdData(rdData), .eolcN(eolcN)
  );

  always #2.5 clk = ~clk;

  function automatic logic [13:0] resultOf(int ch, int sd);
    return 14'((ch * 2731 + sd * 97 + 8000) & 16'h3FFF);
  endfunction

  function automatic int lowestBit(logic [7:0] m);
    for (int i = 0; i < 8; i++) if (m[i]) return i;
    return 0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelUpdate();
    bit st;
    bit wasBusy;
    logic [15:0] v1, v2;
    wasBusy = mBusy;
    st = startRd || (hwSrcSel ? (mPrevT && !timerOut) : (mPrevE && !extTrig));
    if (rdEn) begin
      v1 = (q.size() > 0) ? q.pop_front() : mLast;
      if (rdWide) begin
        v2 = (q.size() > 0) ? q.pop_front() : v1;
        mRd = {v2, v1};
        mLast = v2;
      end else begin
        mRd = {16'h0, v1};
        mLast = v1;
      end
    end
    mHold = 0;
    if (wasBusy && convValid) begin
      int c = lowestBit(mLeft);
      if (q.size() < 8) q.push_back({2'b00, convData});
      mLeft[c] = 1'b0;
      if (mLeft == 0) begin mBusy = 0; mEolcN = 0; end
    end
    if (!wasBusy && st) begin
      q.delete();
      if (chanMask == 0) mEolcN = 0;
      else begin mBusy = 1; mLeft = chanMask; mEolcN = 1; mHold = 1; end
    end
    mPrevE = extTrig;
    mPrevT = timerOut;
  endtask

  task automatic converterModel();
    if (convValid) convValid = 1'b0;
    if (!cBusy && convReq) begin
      cBusy = 1; cCnt = lat; cChan = int'(convChan);
    end
    if (cBusy) begin
      if (cCnt == 0) begin
        convValid = 1'b1;
        convData = resultOf(cChan, seed);
        cBusy = 0;
      end else cCnt--;
    end
  endtask

  task automatic step();
    modelUpdate();
    @(posedge clk);
    @(negedge clk);
    converterModel();
    if (sampleHold) holdSeen++;
    chk("R5", 32'(eolcN), 32'(mEolcN));
    chk("R2", 32'(convReq), 32'(mBusy));
    if (mBusy) chk("R1", 32'(convChan), 32'(lowestBit(mLeft)));
    chk("R4", 32'(sampleHold), 32'(mHold));
    chk("R7", rdData, mRd);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic swStart(logic [7:0] m);
    chanMask = m; startRd = 1'b1; step(); startRd = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 200 && mBusy; i++) step();
  endtask

  task automatic readOne(bit wide);
    rdEn = 1'b1; rdWide = wide; step(); rdEn = 1'b0; rdWide = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int h0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", 32'(eolcN), 0);
    chk("R12", 32'(convReq), 0);
    chk("R12", 32'(sampleHold), 0);
    chk("R12", rdData, 0);
    rstN = 1'b1;
    idle(2);

    // sparse mask, software start
    seed = 1; lat = 2;
    swStart(8'hA5);
    chk("R2", 32'(convReq), 1);
    chk("R5", 32'(eolcN), 1);
    waitDone();
    chk("R5", 32'(eolcN), 0);
    idle(3);
    chk("R5", 32'(eolcN), 0);
    readOne(0);
    chk("R7", rdData, {16'h0, 2'b00, resultOf(0, 1)});
    readOne(0);
    chk("R7", rdData, {16'h0, 2'b00, resultOf(2, 1)});
    readOne(1);
    chk("R8", rdData, {2'b00, resultOf(7, 1), 2'b00, resultOf(5, 1)});
    readOne(1);
    chk("R10", rdData, {2'b00, resultOf(7, 1), 2'b00, resultOf(7, 1)});

    // full mask, launches while busy are ignored
    seed = 2; lat = 0;
    h0 = holdSeen;
    swStart(8'hFF);
    startRd = 1'b1; step(); startRd = 1'b0;
    extTrig = 1'b0; step(); extTrig = 1'b1;
    step();
    startRd = 1'b1; step(); startRd = 1'b0;
    waitDone();
    chk("R9", 32'(holdSeen - h0), 1);
    for (int i = 0; i < 4; i++) begin
      readOne(1);
      chk("R8", rdData, {2'b00, resultOf(2 * i + 1, 2), 2'b00, resultOf(2 * i, 2)});
    end
    readOne(0);
    chk("R10", rdData, {16'h0, 2'b00, resultOf(7, 2)});

    // refill without drain: flush on launch
    seed = 3; lat = 1;
    swStart(8'h03);
    waitDone();
    seed = 4; lat = 3;
    swStart(8'h0C);
    waitDone();
    readOne(0);
    chk("R6", rdData, {16'h0, 2'b00, resultOf(2, 4)});

    // hardware sources
    seed = 5; lat = 1;
    chanMask = 8'h42; hwSrcSel = 1'b0;
    timerOut = 1'b0; step(); timerOut = 1'b1; step();
    chk("R3", 32'(convReq), 0);
    extTrig = 1'b0; step(); extTrig = 1'b1;
    chk("R3", 32'(convReq), 1);
    waitDone();
    readOne(1);
    chk("R3", rdData, {2'b00, resultOf(6, 5), 2'b00, resultOf(1, 5)});
    seed = 6; hwSrcSel = 1'b1; chanMask = 8'h81;
    extTrig = 1'b0; step(); extTrig = 1'b1; step();
    chk("R3", 32'(convReq), 0);
    timerOut = 1'b0; step();
    chk("R3", 32'(convReq), 1);
    timerOut = 1'b1;
    waitDone();

    // zero mask after a scan left entries
    swStart(8'h00);
    chk("R11", 32'(convReq), 0);
    chk("R11", 32'(eolcN), 0);
    idle(2);
    chk("R11", 32'(sampleHold), 0);
    readOne(1);
    chk("R11", rdData, {2'b00, resultOf(6, 5), 2'b00, resultOf(6, 5)});

    idle(4);
    finishRun();
  end
endmodule